// File: doc/BRIEF.md
# ECC Write-Path Error Injector

This block sits between an ECC encoder and a memory array on the write side. A 16-bit control register, written and read through a simple register port, decides whether the codeword passing through is corrupted on its way into the array. Corruption takes the form of a single inverted bit, which a later read sees as a correctable error, or two adjacent inverted bits, which a later read sees as a non-correctable error. Each kind can be armed continuously or for one write only, and one control bit chooses which of two arrays is affected.

The data path is purely combinational: the output codeword follows the input codeword in the same cycle, with the flip mask applied only while the write strobe is high, the array id matches the selected array, and the bit-select value lies inside the codeword. The register is the only state. One-shot requests retire themselves on the clock edge that ends the write they corrupted.

Top module: `ecc_write_injector`

## Requirements
- R1: The control register resets to 0x0000, is 16 bits wide, and reads back only its writable fields: bit 13 continuous single, bit 12 one-shot single, bit 9 continuous double, bit 8 one-shot double, bit 7 array select, bits 5:0 bit select; every other bit reads 0 (writing 0xFFFF reads back 0x33BF).
- R2: While the write strobe is low the output codeword equals the input codeword.
- R3: A single-bit injection inverts exactly the codeword bit named by the bit-select field.
- R4: A double-bit injection inverts the selected bit and the bit one position above it; selecting the top bit (CW_WIDTH-1) pairs it with bit 0.
- R5: When any double-bit request (bit 9 or bit 8) is set together with a single-bit request, the double-bit injection is applied.
- R6: A one-shot bit clears on the clock edge that ends the first write it corrupted; a continuous bit stays set until software rewrites the register.
- R7: A single-bit one-shot that was overridden by a double-bit request stays pending.
- R8: Injection happens only when the array id input equals the array select bit; other writes pass unchanged and leave one-shot bits set.
- R9: A bit-select value of CW_WIDTH or more disables injection: the codeword passes unchanged and one-shot bits stay set.
- R10: A register write in the same cycle as a qualifying write takes the written value; the injection in that cycle uses the register contents before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write enable |
| regWrData | input | 16 | Control register write data |
| regRdData | output | 16 | Control register contents |
| wrStrobe | input | 1 | Memory write cycle in progress |
| arrayId | input | 1 | Array targeted by the current write |
| cwIn | input | CW_WIDTH | Codeword from the ECC encoder |
| cwOut | output | CW_WIDTH | Codeword to the memory array |

## Verification
Every cycle the assertions confirm that reserved bits read zero, that idle cycles, non-matching arrays and out-of-range selects leave the codeword untouched, that no more than two bits (one when no double request is set) ever differ, that an applied double one-shot retires, that continuous bits persist, and that a register write lands as written. Which exact bits flip, the wrap from the top bit to bit 0, the precedence of double over single and the survival of an overridden single one-shot depend on specific register values and sequences, so only the bench's scenarios show them.

// File: rtl/eccinj_pkg.sv
package eccinj_pkg;

  localparam int REG_W = 16;
  localparam int SEL_W = 6;

  // control register field positions
  localparam int F_CONT_SGL = 13;
  localparam int F_SHOT_SGL = 12;
  localparam int F_CONT_DBL = 9;
  localparam int F_SHOT_DBL = 8;
  localparam int F_ARR_SEL  = 7;

  localparam logic [REG_W-1:0] WRITABLE = 16'h33BF;

  // strobes from control to datapath
  typedef struct packed {
    logic injEn;
    logic injDouble;
  } injStrobe_t;

endpackage

// File: rtl/eccinj_ctrl.sv
module eccinj_ctrl
  import eccinj_pkg::*;
#(
  parameter int CW_WIDTH = 39
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             wrStrobe,
  input  logic             arrayId,
  output injStrobe_t       strobe,
  output logic [SEL_W-1:0] bitSel
);

  localparam logic [SEL_W:0] CW_LIMIT = (SEL_W+1)'(CW_WIDTH);

  logic [REG_W-1:0] ctlReg;
  logic anyDouble, anySingle, selValid, armed;
  logic clrSingleShot, clrDoubleShot;

  always_comb begin
    bitSel        = ctlReg[SEL_W-1:0];
    anyDouble     = ctlReg[F_CONT_DBL] | ctlReg[F_SHOT_DBL];
    anySingle     = ctlReg[F_CONT_SGL] | ctlReg[F_SHOT_SGL];
    selValid      = {1'b0, bitSel} < CW_LIMIT;
    armed         = wrStrobe && (arrayId == ctlReg[F_ARR_SEL]) && selValid;
    strobe.injEn     = armed && (anyDouble || anySingle);
    strobe.injDouble = anyDouble;
    clrDoubleShot = armed && ctlReg[F_SHOT_DBL];
    clrSingleShot = armed && ctlReg[F_SHOT_SGL] && !anyDouble;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
    end else if (regWrEn) begin
      ctlReg <= regWrData & WRITABLE;
    end else begin
      if (clrSingleShot) ctlReg[F_SHOT_SGL] <= 1'b0;
      if (clrDoubleShot) ctlReg[F_SHOT_DBL] <= 1'b0;
    end
  end

  assign regRdData = ctlReg;

endmodule

// File: rtl/eccinj_datapath.sv
module eccinj_datapath
  import eccinj_pkg::*;
#(
  parameter int CW_WIDTH = 39
) (
  input  injStrobe_t          strobe,
  input  logic [SEL_W-1:0]    bitSel,
  input  logic [CW_WIDTH-1:0] cwIn,
  output logic [CW_WIDTH-1:0] cwOut
);

  logic [CW_WIDTH-1:0] flipMask;

  for (genvar i = 0; i < CW_WIDTH; i++) begin : g_mask
    localparam logic [SEL_W-1:0] HERE  = SEL_W'(i);
    localparam logic [SEL_W-1:0] BELOW = SEL_W'((i == 0) ? CW_WIDTH - 1 : i - 1);
    assign flipMask[i] = strobe.injEn &&
                         ((bitSel == HERE) || (strobe.injDouble && (bitSel == BELOW)));
  end

  assign cwOut = cwIn ^ flipMask;

endmodule

// File: rtl/ecc_write_injector.sv
module ecc_write_injector
  import eccinj_pkg::*;
#(
  parameter int CW_WIDTH = 39
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [15:0]         regWrData,
  output logic [15:0]         regRdData,
  input  logic                wrStrobe,
  input  logic                arrayId,
  input  logic [CW_WIDTH-1:0] cwIn,
  output logic [CW_WIDTH-1:0] cwOut
);

  injStrobe_t       strobe;
  logic [SEL_W-1:0] bitSel;

  eccinj_ctrl #(.CW_WIDTH(CW_WIDTH)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .wrStrobe  (wrStrobe),
    .arrayId   (arrayId),
    .strobe    (strobe),
    .bitSel    (bitSel)
  );

  eccinj_datapath #(.CW_WIDTH(CW_WIDTH)) dp_i (
    .strobe (strobe),
    .bitSel (bitSel),
    .cwIn   (cwIn),
    .cwOut  (cwOut)
  );

endmodule

// File: rtl/eccinj_checker.sv
module eccinj_checker #(
  parameter int CW_WIDTH = 39
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic [15:0]         regWrData,
  input logic [15:0]         regRdData,
  input logic                wrStrobe,
  input logic                arrayId,
  input logic [CW_WIDTH-1:0] cwIn,
  input logic [CW_WIDTH-1:0] cwOut
);

  logic [CW_WIDTH-1:0] diff;
  logic                inRange;
  assign diff    = cwOut ^ cwIn;
  assign inRange = {1'b0, regRdData[5:0]} < 7'(CW_WIDTH);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~16'h33BF) == 16'h0);

  a_r2_idle_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> (cwOut == cwIn));

  a_r4_at_most_two: assert property (@(posedge clk) disable iff (!rstN)
    $countones(diff) <= 2);

  a_r3_single_only: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[9:8] == 2'b00) |-> ($countones(diff) <= 1));

  a_r8_other_array: assert property (@(posedge clk) disable iff (!rstN)
    (arrayId != regRdData[7]) |-> (cwOut == cwIn));

  a_r9_bad_select: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> (cwOut == cwIn));

  a_r6_oneshot_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && wrStrobe && (arrayId == regRdData[7]) && inRange && regRdData[8])
    |=> !regRdData[8]);

  a_r6_continuous_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && regRdData[13] && regRdData[9]) |=> (regRdData[13] && regRdData[9]));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (regRdData == ($past(regWrData) & 16'h33BF)));

endmodule

bind ecc_write_injector eccinj_checker #(.CW_WIDTH(CW_WIDTH)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .wrStrobe  (wrStrobe),
  .arrayId   (arrayId),
  .cwIn      (cwIn),
  .cwOut     (cwOut)
);

// File: tb/ecc_write_injector_tb.sv
module ecc_write_injector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 39;

  typedef struct packed {
    logic [15:0]   ctl;
    logic          arr;
    logic          stb;
    logic [CW-1:0] cw;
    logic [CW-1:0] flip;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16'h2005, 1'b0, 1'b1, 39'h12_3456_789A, 39'h20},               // R3 single bit 5
    '{16'h2005, 1'b0, 1'b0, 39'h12_3456_789A, 39'h0},                // R2 strobe low
    '{16'h020A, 1'b0, 1'b1, 39'h7F_0F0F_0F0F, 39'hC00},              // R4 bits 10,11
    '{16'h0226, 1'b0, 1'b1, 39'h55_5555_5555, 39'h40_0000_0001},     // R4 wrap 38->0
    '{16'h2283, 1'b1, 1'b1, 39'h00_0000_0000, 39'h18},               // R5 double wins
    '{16'h2283, 1'b0, 1'b1, 39'h2A_AAAA_AAAA, 39'h0},                // R8 wrong array
    '{16'h2027, 1'b0, 1'b1, 39'h33_3333_3333, 39'h0},                // R9 select 39
    '{16'h2026, 1'b0, 1'b1, 39'h01_2345_6789, 39'h40_0000_0000}      // R3 top bit
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [15:0]   regWrData = '0;
  logic [15:0]   regRdData;
  logic          wrStrobe = 1'b0;
  logic          arrayId = 1'b0;
  logic [CW-1:0] cwIn = '0;
  logic [CW-1:0] cwOut;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_write_injector #(.CW_WIDTH(CW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .wrStrobe(wrStrobe), .arrayId(arrayId),
    .cwIn(cwIn), .cwOut(cwOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] v);
    @(negedge clk);
    wrStrobe  = 1'b0;
    regWrEn   = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  // drive a write at a negedge, check the output, then let one edge pass
  task automatic memWrite(input string req, input logic arr, input logic [CW-1:0] cw,
                          input logic [CW-1:0] flip);
    wrStrobe = 1'b1;
    arrayId  = arr;
    cwIn     = cw;
    #1;
    check(req, 64'(cwOut), 64'(cw ^ flip));
    @(negedge clk);
    wrStrobe = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", 64'(regRdData), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reserved bits read zero
    regWrite(16'hFFFF);
    check("R1 writable mask", 64'(regRdData), 64'h33BF);

    // vector table, continuous modes only
    for (int k = 0; k < NVEC; k++) begin
      regWrite(VECS[k].ctl);
      wrStrobe = VECS[k].stb;
      arrayId  = VECS[k].arr;
      cwIn     = VECS[k].cw;
      #1;
      check($sformatf("R2-R9 vector %0d", k), 64'(cwOut), 64'(VECS[k].cw ^ VECS[k].flip));
      @(negedge clk);
      check($sformatf("R6 continuous kept %0d", k), 64'(regRdData), 64'(VECS[k].ctl));
    end

    // R6: single one-shot fires once then clears
    regWrite(16'h1004);
    memWrite("R6 one-shot single fires", 1'b0, 39'h0F_F00F_F00F, 39'h10);
    check("R6 one-shot single cleared", 64'(regRdData), 64'h0004);
    memWrite("R6 no second injection", 1'b0, 39'h0F_F00F_F00F, 39'h0);

    // R8: double one-shot on array 1, first write to array 0
    regWrite(16'h0187);
    memWrite("R8 other array untouched", 1'b0, 39'h11_1111_1111, 39'h0);
    check("R8 one-shot kept", 64'(regRdData), 64'h0187);
    memWrite("R8 selected array injects", 1'b1, 39'h11_1111_1111, 39'h180);
    check("R6 one-shot double cleared", 64'(regRdData), 64'h0087);

    // R5 / R7: single one-shot with continuous double
    regWrite(16'h1202);
    memWrite("R5 double precedence", 1'b0, 39'h7F_FFFF_FFFF, 39'hC);
    check("R7 single one-shot pending", 64'(regRdData), 64'h1202);

    // R9: out-of-range select
    regWrite(16'h102D);
    memWrite("R9 select 45 no flip", 1'b0, 39'h24_6813_579B, 39'h0);
    check("R9 one-shot kept", 64'(regRdData), 64'h102D);

    // R10: register write coinciding with a qualifying write
    regWrite(16'h1001);
    regWrEn   = 1'b1;
    regWrData = 16'h1003;
    memWrite("R10 old value injects", 1'b0, 39'h0, 39'h2);
    regWrEn   = 1'b0;
    check("R10 written value wins", 64'(regRdData), 64'h1003);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule